// File: doc/BRIEF.md
# Chained Vector Add-Shift Unit

This block runs two vector operations back to back over one vector length. The first is an element-wise add of two source vectors in a fully pipelined adder. The second is a logical right shift of each sum by an amount fixed when the run starts. The sums go into an intermediate vector register. A one-bit "written" mark sits beside each element of that register. The shifter takes element i as soon as its mark is set, so it does not wait for the whole intermediate vector to fill. This is chaining: the dependent operation overlaps the producing one, and a whole run takes about the sum of both latencies plus the vector length.

A run begins with a one-cycle start pulse that carries the length and the shift amount. The block points at the source element it wants through `readIdx`. The surrounding logic presents that element's two operands in the same cycle and raises `srcValid` when they are usable. Results leave in index order on `outValid`/`outIdx`/`outElem`. A single-cycle `done` pulse closes the run.

Top module: `vec_chain_unit`

## Requirements
- R1: After reset, `outValid` and `done` are low and `readIdx` is 0.
- R2: Each result equals the 16-bit wrapped sum of the two operands, logically shifted right by `shiftAmt` as sampled with `start`. Results appear on `outIdx` in order 0, 1, ..., n-1.
- R3: An accepted start clears every written mark of the intermediate register. A mark is set in the same edge its element is written.
- R4: With `srcValid` held high, element i appears on the output i+5 cycles after the clock edge that accepted `start`, one element per cycle.
- R5: The shifter takes element i only once its mark is set. An element accepted from the sources at edge k leaves the output at edge k+4, whatever gaps came before it.
- R6: `done` is a one-cycle pulse in the cycle after the last result. With no source stalls it comes n+5 cycles after the accepting edge.
- R7: A `start` raised while a run is in progress is ignored. The run keeps its length and shift, and no extra run follows.
- R8: A `vecLen` of 0 or above 64 runs the full 64 elements.
- R9: In a cycle with `srcValid` low, no element is taken: `readIdx` holds and a gap appears in the output stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (ignored while busy) |
| vecLen | input | 7 | Element count, 1..64 (0 or >64 means 64) |
| shiftAmt | input | 4 | Right-shift amount applied by the second unit |
| srcValid | input | 1 | Operands for `readIdx` are usable this cycle |
| aElem | input | 16 | First operand of element `readIdx` |
| bElem | input | 16 | Second operand of element `readIdx` |
| readIdx | output | 6 | Index of the source element wanted |
| outValid | output | 1 | A result is on `outElem` |
| outIdx | output | 6 | Index of that result |
| outElem | output | 16 | Shifted sum |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench drives runs of several lengths: 1, 8, 0 meaning 64, and 100 clamped to 64. Operands include sums that overflow, and shift amounts differ from run to run. This separates the wrapped-sum-and-shift value from any indexing or clamping error. An unbroken source stream pins down the exact chained timing of first result and `done`. A stream with a gap in every third cycle shows that each result trails its own accepted source element by a fixed four cycles, so the marks gate the shifter per element and no stale element slips through. A second start raised in mid-run must leave the element count, values and the single `done` unchanged.

// File: rtl/vec_chain_pkg.sv
package vec_chain_pkg;
  localparam int MAX_ELEMS = 64;
  localparam int IDX_W = $clog2(MAX_ELEMS);
  localparam int LEN_W = $clog2(MAX_ELEMS + 1);

  typedef struct packed {
    logic             launch;
    logic             prodFire;
    logic [IDX_W-1:0] prodIdx;
    logic             consFire;
    logic [IDX_W-1:0] consIdx;
  } vc_strobe_t;
endpackage

// File: rtl/vec_chain_ctrl.sv
module vec_chain_ctrl
  import vec_chain_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] vecLen,
  input  logic             srcValid,
  input  logic             markHit,
  output vc_strobe_t       strobe,
  output logic             done
);
  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(MAX_ELEMS);

  logic             busy, prodAll, consAll, doneR;
  logic [LEN_W-1:0] lenReg, effLen;
  logic [IDX_W-1:0] prodIdx, consIdx;
  logic             startOk, prodFire, consFire;

  assign effLen   = (vecLen == '0 || vecLen > FULL_LEN) ? FULL_LEN : vecLen;
  assign startOk  = start && !busy;
  assign prodFire = busy && !prodAll && srcValid;
  assign consFire = busy && !consAll && markHit;

  always_comb begin
    strobe.launch   = startOk;
    strobe.prodFire = prodFire;
    strobe.prodIdx  = prodIdx;
    strobe.consFire = consFire;
    strobe.consIdx  = consIdx;
  end
  assign done = doneR;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; prodAll <= 1'b0; consAll <= 1'b0; doneR <= 1'b0;
      lenReg <= '0; prodIdx <= '0; consIdx <= '0;
    end else if (startOk) begin
      busy <= 1'b1; prodAll <= 1'b0; consAll <= 1'b0; doneR <= 1'b0;
      lenReg <= effLen; prodIdx <= '0; consIdx <= '0;
    end else begin
      if (prodFire) begin
        if (LEN_W'(prodIdx) == lenReg - LEN_W'(1)) prodAll <= 1'b1;
        else prodIdx <= prodIdx + IDX_W'(1);
      end
      if (consFire) begin
        if (LEN_W'(consIdx) == lenReg - LEN_W'(1)) consAll <= 1'b1;
        else consIdx <= consIdx + IDX_W'(1);
      end
      doneR <= busy && consAll;
      if (busy && consAll) busy <= 1'b0;
    end
  end

  // R9: a stalled source leaves the producer index where it was
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !srcValid && !startOk) |=> $stable(prodIdx));
  // R6: done never lasts two cycles
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    doneR |=> !doneR);
  // R7: a start during a run leaves the length alone
  a_r7_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> $stable(lenReg));
endmodule

// File: rtl/vec_chain_dp.sv
module vec_chain_dp
  import vec_chain_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADD_LAT = 4,
  localparam int SH_W   = $clog2(DATA_W),
  localparam int STG    = ADD_LAT - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  vc_strobe_t        strobe,
  input  logic [SH_W-1:0]   shiftAmt,
  input  logic [DATA_W-1:0] aElem,
  input  logic [DATA_W-1:0] bElem,
  output logic              markHit,
  output logic              outValid,
  output logic [IDX_W-1:0]  outIdx,
  output logic [DATA_W-1:0] outElem
);
  logic                 pValid [STG];
  logic [IDX_W-1:0]     pIdx   [STG];
  logic [DATA_W-1:0]    pData  [STG];
  logic [DATA_W-1:0]    midReg [MAX_ELEMS];
  logic [MAX_ELEMS-1:0] marks;
  logic [SH_W-1:0]      shReg;

  assign markHit = marks[strobe.consIdx];

  // adder pipeline; the write into midReg is its last stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < STG; k++) pValid[k] <= 1'b0;
    end else begin
      pValid[0] <= strobe.prodFire;
      for (int k = 1; k < STG; k++) pValid[k] <= pValid[k-1];
    end
  end

  always_ff @(posedge clk) begin
    pIdx[0]  <= strobe.prodIdx;
    pData[0] <= aElem + bElem;
    for (int k = 1; k < STG; k++) begin
      pIdx[k]  <= pIdx[k-1];
      pData[k] <= pData[k-1];
    end
    if (pValid[STG-1]) midReg[pIdx[STG-1]] <= pData[STG-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      marks <= '0;
      shReg <= '0;
    end else if (strobe.launch) begin
      marks <= '0;
      shReg <= shiftAmt;
    end else if (pValid[STG-1]) begin
      marks[pIdx[STG-1]] <= 1'b1;
    end
  end

  // shift unit, one stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outIdx   <= '0;
      outElem  <= '0;
    end else begin
      outValid <= strobe.consFire;
      if (strobe.consFire) begin
        outIdx  <= strobe.consIdx;
        outElem <= midReg[strobe.consIdx] >> shReg;
      end
    end
  end

  // R5: the shifter only reads a marked element
  a_r5_chain_gate: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.consFire |-> marks[strobe.consIdx]);
  // R3: launch leaves every mark clear
  a_r3_marks_clear: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.launch |=> (marks == '0));
  // R3: a written element is marked at the next edge
  a_r3_mark_set: assert property (@(posedge clk) disable iff (!rst_n)
    (pValid[STG-1] && !strobe.launch) |=> marks[$past(pIdx[STG-1])]);
endmodule

// File: rtl/vec_chain_unit.sv
module vec_chain_unit
  import vec_chain_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADD_LAT = 4,
  localparam int SH_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  vecLen,
  input  logic [SH_W-1:0]   shiftAmt,
  input  logic              srcValid,
  input  logic [DATA_W-1:0] aElem,
  input  logic [DATA_W-1:0] bElem,
  output logic [IDX_W-1:0]  readIdx,
  output logic              outValid,
  output logic [IDX_W-1:0]  outIdx,
  output logic [DATA_W-1:0] outElem,
  output logic              done
);
  vc_strobe_t strobe;
  logic       markHit;

  vec_chain_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .vecLen(vecLen),
    .srcValid(srcValid), .markHit(markHit), .strobe(strobe), .done(done)
  );

  vec_chain_dp #(.DATA_W(DATA_W), .ADD_LAT(ADD_LAT)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .shiftAmt(shiftAmt),
    .aElem(aElem), .bElem(bElem), .markHit(markHit),
    .outValid(outValid), .outIdx(outIdx), .outElem(outElem)
  );

  assign readIdx = strobe.prodIdx;

  // R6: done follows directly on the last result
  a_r6_done_after_out: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(outValid));
endmodule

// File: tb/vec_chain_unit_bench.sv
module vec_chain_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  vecLen = '0;
  logic [3:0]  shiftAmt = '0;
  logic        srcValid = 1'b0;
  logic [15:0] aElem, bElem;
  logic [5:0]  readIdx, outIdx;
  logic        outValid, done;
  logic [15:0] outElem;

  logic [15:0] aMem [64];
  logic [15:0] bMem [64];

  typedef struct { int idx; logic [15:0] val; int cyc; } exp_t;
  exp_t expQ[$];

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int doneCount = 0;
  int doneCyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign aElem = aMem[readIdx];
  assign bElem = bMem[readIdx];

  vec_chain_unit u_vec_chain_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .vecLen(vecLen),
    .shiftAmt(shiftAmt), .srcValid(srcValid), .aElem(aElem), .bElem(bElem),
    .readIdx(readIdx), .outValid(outValid), .outIdx(outIdx),
    .outElem(outElem), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (outValid) begin
        if (expQ.size() == 0) begin
          check(0, "R7 unexpected result", outIdx, -1);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check(int'(outIdx) == e.idx, "R2 index order", outIdx, e.idx);
          check(outElem == e.val, "R2 value", outElem, e.val);
          check(cyc == e.cyc, "R4/R5 result cycle", cyc, e.cyc);
        end
      end
      if (done) begin
        doneCount++;
        doneCyc = cyc;
      end
    end
  end

  task automatic runVec(input int len, input int sh, input bit stall,
                        input bit poke, input int seed);
    int effN, acc, k, startCyc, lastCyc, prevDone;
    bit v;
    effN = (len == 0 || len > 64) ? 64 : len;
    for (int i = 0; i < 64; i++) begin
      aMem[i] = (i % 5 == 0) ? 16'hFFF0 - 16'(i) : 16'(i * seed + 13);
      bMem[i] = 16'(i * i * 7 + seed * 3 + 40);
    end
    prevDone = doneCount;
    @(negedge clk);
    start = 1'b1; vecLen = 7'(len); shiftAmt = 4'(sh); srcValid = 1'b0;
    startCyc = cyc + 1;
    @(negedge clk);
    start = 1'b0;
    acc = 0; k = 0; lastCyc = 0;
    while (acc < effN) begin
      v = !stall || (k % 3 != 1);
      srcValid = v;
      // R7: a second start while busy, different length and shift
      if (poke && k == 3) begin start = 1'b1; vecLen = 7'd3; shiftAmt = 4'd9; end
      else start = 1'b0;
      if (v) begin
        exp_t e;
        logic [15:0] s;
        s = aMem[acc] + bMem[acc];
        e.idx = acc; e.val = s >> sh; e.cyc = cyc + 1 + 4;
        expQ.push_back(e);
        lastCyc = e.cyc;
        acc++;
      end
      k++;
      @(negedge clk);
    end
    srcValid = 1'b0; start = 1'b0;
    while (doneCount == prevDone && cyc < startCyc + 400) @(negedge clk);
    check(doneCount == prevDone + 1, "R6 done seen", doneCount - prevDone, 1);
    check(doneCyc == lastCyc + 1, "R6 done timing", doneCyc, lastCyc + 1);
    if (!stall)
      check(doneCyc == startCyc + effN + 5, "R4/R6 chained total", doneCyc - startCyc, effN + 5);
    check(expQ.size() == 0, "R2/R8 element count", expQ.size(), 0);
    repeat (6) @(negedge clk);
    check(doneCount == prevDone + 1, "R6/R7 single done", doneCount - prevDone, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(outValid == 1'b0, "R1 outValid", outValid, 0);
    check(done == 1'b0, "R1 done", done, 0);
    check(readIdx == 6'd0, "R1 readIdx", readIdx, 0);
    runVec(8, 1, 0, 0, 11);     // R2 R4 R6
    runVec(1, 0, 0, 0, 5);      // R4 boundary length
    runVec(12, 3, 1, 0, 29);    // R5 R9 stalled source
    // R9: readIdx holds while srcValid is low
    check(readIdx == 6'd11, "R9 readIdx after run", readIdx, 11);
    runVec(0, 2, 0, 0, 3);      // R8 zero means full
    runVec(100, 15, 0, 0, 17);  // R8 clamp
    runVec(10, 4, 0, 1, 23);    // R7 start while busy
    runVec(20, 1, 1, 1, 41);    // R5 R7 R9 combined
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule